// File: doc/BRIEF.md
# Two-Bank Non-Volatile Configuration RAM with Identity Bytes

This block models the byte store that sits behind a real-time clock and keeps
configuration while main power is off. It offers 128 byte addresses per bank
and two banks. The lower half of the address space, 0x00 to 0x3F, is a single
shared storage area that both banks reach. Above 0x3F the bank-select input
picks what is seen. Bank 0 shows ordinary writable bytes. Bank 1 shows a fixed
eight-byte machine identity, followed by one century byte and a reserved gap.

The identity consists of a version byte, then six serial-number bytes, then a
check byte. The check byte is a CRC-8 over the seven bytes before it. The
identity bytes and the CRC are fixed when the block is elaborated. The CRC is
derived from the identity parameter, so software can use it to confirm that
the identity is intact.

The century byte accepts only legal century values for the current date
format. A one-cycle clear-all pulse, driven by tamper-detection logic, erases
every writable byte. The identity is left in place. Software uses one
synchronous byte port with a single address. The port has a write enable and
a registered read result.

Top module: `cmos_banked_ram`

## Requirements
- R1: While reset is held, and until two rising clock edges after reset is released, rd_data is 0x00.
- R2: Addresses 0x00–0x3F reach one shared storage area. A byte written there with either bank_sel value reads back the same with either bank_sel value.
- R3: With bank_sel=0, addresses 0x40–0x7F are independent writable bytes. Accesses with bank_sel=1 to the same addresses never change them.
- R4: With bank_sel=1, address 0x40 reads ID_VALUE[7:0] (version). Address 0x40+k for k=1..6 reads ID_VALUE[8k+7:8k] (serial). Address 0x47 reads CRC-8 with reflected polynomial 0x8C (x^8+x^5+x^4+1), initial value 0x00, taken over bytes 0x40..0x46 in address order with each byte fed least-significant bit first.
- R5: Writes with bank_sel=1 to 0x40–0x47 are ignored, and those bytes keep reading their fixed values.
- R6: With bank_sel=1, 0x48 is the century byte. With date_bcd=1 a write is accepted only when both nibbles are 0–9. With date_bcd=0 a write is accepted only when the value is 0x00–0x63 (0–99). A rejected write leaves the old value.
- R7: With bank_sel=1, addresses 0x49–0x7F read 0x00, and writes to them are ignored.
- R8: A clear_all pulse at a clock edge zeroes the shared bytes, the bank 0 upper bytes and the century byte, and it takes priority over a write in the same cycle. The identity bytes and the CRC do not change.
- R9: rd_data is registered. After a clock edge it holds the byte at the address sampled at that edge. A write at that edge is not yet visible, so the read returns the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_sel | input | 1 | Bank choice for addresses 0x40 and above (0 or 1) |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe for the addressed byte |
| wr_data | input | 8 | Byte to write |
| date_bcd | input | 1 | Date format: 1 = BCD, 0 = binary; sets the century range check |
| clear_all | input | 1 | One-cycle erase of all writable bytes |
| rd_data | output | 8 | Registered read byte |

## Verification
Every stored byte is visible only through rd_data, so a wrong internal state
appears at the ports on the first read of the affected address. That result
arrives one clock edge after the address is presented. A shared byte held
twice, or a bank decode error, shows up when a value written through one bank
reads differently through the other. A weak write filter on the identity,
reserved or century addresses shows up as a changed byte on the read after
the rejected write. An incomplete clear shows up as a nonzero byte in the
first read after the pulse.

// File: rtl/cmos_bank_pkg.sv
package cmos_bank_pkg;

  localparam int BYTE_W      = 8;
  localparam int ID_BYTES    = 8;
  localparam int ID_BODY_W   = (ID_BYTES - 1) * BYTE_W;
  localparam logic [BYTE_W-1:0] CRC8_POLY_REFL = 8'h8C;

  typedef enum logic [2:0] {
    RG_SHARED,
    RG_LOW_BANK,
    RG_IDENT,
    RG_CENTURY,
    RG_RESERVED
  } region_t;

  // Reflected CRC-8, bit-serial, least significant bit of the message first.
  function automatic logic [BYTE_W-1:0] crc8_lsb_first(input logic [ID_BODY_W-1:0] msg);
    logic [BYTE_W-1:0] acc;
    logic              fb;
    acc = '0;
    for (int i = 0; i < ID_BODY_W; i++) begin
      fb  = acc[0] ^ msg[i];
      acc = acc >> 1;
      if (fb) acc = acc ^ CRC8_POLY_REFL;
    end
    return acc;
  endfunction

  function automatic logic century_ok(input logic [BYTE_W-1:0] v, input logic bcd);
    logic ok;
    if (bcd) ok = (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
    else     ok = (v <= 8'd99);
    return ok;
  endfunction

endpackage

// File: rtl/cmos_rst_sync.sv
module cmos_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign core_rst_n = sync_q[1];
endmodule

// File: rtl/cmos_region_dec.sv
module cmos_region_dec
  import cmos_bank_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              bank_sel,
  input  logic [ADDR_W-1:0] addr,
  output region_t           region,
  output logic [ADDR_W-2:0] row,
  output logic [2:0]        id_sel
);
  localparam int HALF    = 2 ** (ADDR_W - 1);
  localparam int ID_LAST = HALF + ID_BYTES - 1;
  localparam int CENT    = HALF + ID_BYTES;
  localparam logic [ADDR_W-1:0] HALF_A    = ADDR_W'(HALF);
  localparam logic [ADDR_W-1:0] ID_LAST_A = ADDR_W'(ID_LAST);
  localparam logic [ADDR_W-1:0] CENT_A    = ADDR_W'(CENT);

  always_comb begin
    row    = addr[ADDR_W-2:0];
    id_sel = addr[2:0];
    if (addr < HALF_A)          region = RG_SHARED;
    else if (!bank_sel)         region = RG_LOW_BANK;
    else if (addr <= ID_LAST_A) region = RG_IDENT;
    else if (addr == CENT_A)    region = RG_CENTURY;
    else                        region = RG_RESERVED;
  end
endmodule

// File: rtl/cmos_id_rom.sv
module cmos_id_rom
  import cmos_bank_pkg::*;
#(
  parameter logic [ID_BODY_W-1:0] ID_VALUE = '0
) (
  input  logic [2:0]        sel,
  output logic [BYTE_W-1:0] id_byte
);
  localparam logic [BYTE_W-1:0]             CHECK = crc8_lsb_first(ID_VALUE);
  localparam logic [ID_BYTES*BYTE_W-1:0]    IMAGE = {CHECK, ID_VALUE};

  logic [BYTE_W-1:0] rom [ID_BYTES];

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_rom
    assign rom[g] = IMAGE[g*BYTE_W +: BYTE_W];
  end

  assign id_byte = rom[sel];
endmodule

// File: rtl/cmos_byte_array.sv
module cmos_byte_array
  import cmos_bank_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              clr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wd,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [BYTE_W-1:0] mem [DEPTH];

  // Battery-backed contents: no reset, erased only by clr.
  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wd;
    end
  end

  assign rd_byte = mem[idx];
endmodule

// File: rtl/cmos_banked_ram.sv
module cmos_banked_ram
  import cmos_bank_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ID_BODY_W-1:0] ID_VALUE = 56'h3A_C7_19_E4_52_B8_05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              date_bcd,
  input  logic              clear_all,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int HALF = 2 ** (ADDR_W - 1);

  logic              core_rst_n;
  region_t           region;
  logic [ADDR_W-2:0] row;
  logic [2:0]        id_sel;
  logic              we_ok;
  logic              clr_ok;
  logic              shared_we;
  logic              low_we;
  logic [BYTE_W-1:0] shared_byte;
  logic [BYTE_W-1:0] low_byte;
  logic [BYTE_W-1:0] id_byte;
  logic [BYTE_W-1:0] cent_q;
  logic [BYTE_W-1:0] cent_d;
  logic [BYTE_W-1:0] rd_d;
  logic [BYTE_W-1:0] rd_q;

  cmos_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst_n (core_rst_n)
  );

  cmos_region_dec #(.ADDR_W(ADDR_W)) u_dec (
    .bank_sel (bank_sel),
    .addr     (addr),
    .region   (region),
    .row      (row),
    .id_sel   (id_sel)
  );

  // Write and erase enables, held off while the internal reset is active.
  always_comb begin
    we_ok     = wr_en & core_rst_n;
    clr_ok    = clear_all & core_rst_n;
    shared_we = we_ok && (region == RG_SHARED);
    low_we    = we_ok && (region == RG_LOW_BANK);
  end

  cmos_byte_array #(.DEPTH(HALF)) u_shared (
    .clk     (clk),
    .we      (shared_we),
    .clr     (clr_ok),
    .idx     (row),
    .wd      (wr_data),
    .rd_byte (shared_byte)
  );

  cmos_byte_array #(.DEPTH(HALF)) u_low_bank (
    .clk     (clk),
    .we      (low_we),
    .clr     (clr_ok),
    .idx     (row),
    .wd      (wr_data),
    .rd_byte (low_byte)
  );

  cmos_id_rom #(.ID_VALUE(ID_VALUE)) u_id (
    .sel     (id_sel),
    .id_byte (id_byte)
  );

  // Century byte: next state.
  always_comb begin
    cent_d = cent_q;
    if (clr_ok)
      cent_d = '0;
    else if (we_ok && (region == RG_CENTURY) && century_ok(wr_data, date_bcd))
      cent_d = wr_data;
  end

  // Century byte: battery-backed register, no reset.
  always_ff @(posedge clk) begin
    cent_q <= cent_d;
  end

  // Read selection.
  always_comb begin
    case (region)
      RG_SHARED:   rd_d = shared_byte;
      RG_LOW_BANK: rd_d = low_byte;
      RG_IDENT:    rd_d = id_byte;
      RG_CENTURY:  rd_d = cent_q;
      default:     rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) rd_q <= '0;
    else             rd_q <= rd_d;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/cmos_bank_chk.sv
module cmos_bank_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              core_rst_n,
  input logic              bank_sel,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              clear_all,
  input logic [7:0]        rd_data
);
  localparam int HALF = 2 ** (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] HALF_A = ADDR_W'(HALF);
  localparam logic [ADDR_W-1:0] CENT_A = ADDR_W'(HALF + 8);

  logic id_hit;
  assign id_hit = bank_sel && (addr >= HALF_A) && (addr < CENT_A);

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !core_rst_n |-> rd_data == 8'h00);

  // R5
  id_fixed_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (id_hit && $past(id_hit) && addr == $past(addr)) |=> $stable(rd_data));

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bank_sel && addr > CENT_A) |=> rd_data == 8'h00);

  // R8
  clear_shared_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (clear_all ##1 addr < HALF_A) |=> rd_data == 8'h00);

  // R9
  write_then_read_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && !clear_all && addr < HALF_A ##1 addr == $past(addr) && !clear_all)
      |=> rd_data == $past(wr_data, 2));
endmodule

bind cmos_banked_ram cmos_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .bank_sel   (bank_sel),
  .addr       (addr),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .clear_all  (clear_all),
  .rd_data    (rd_data)
);

// File: tb/tb_cmos_banked_ram.sv
module tb_cmos_banked_ram;
  localparam logic [55:0] TB_ID = 56'h3A_C7_19_E4_52_B8_05;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bank_sel;
  logic [6:0] addr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       date_bcd;
  logic       clear_all;
  logic [7:0] rd_data;

  always #10 clk = ~clk;

  cmos_banked_ram #(.ADDR_W(7), .ID_VALUE(TB_ID)) dut (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .date_bcd(date_bcd),
    .clear_all(clear_all), .rd_data(rd_data)
  );

  int         checks = 0;
  int         errors = 0;
  logic       rd_issue = 1'b0;
  bit         done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  function automatic logic [7:0] ref_crc(input logic [55:0] idv);
    logic [7:0] c;
    logic [7:0] by;
    logic       mix;
    c = 8'h00;
    for (int b = 0; b < 7; b++) begin
      by = idv[8*b +: 8];
      for (int k = 0; k < 8; k++) begin
        mix = c[0] ^ by[k];
        c   = {1'b0, c[7:1]} ^ (mix ? 8'h8C : 8'h00);
      end
    end
    return c;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expected read result queued for the monitor.
  task automatic cyc(input logic b, input logic [6:0] a, input logic w, input logic [7:0] d,
                     input logic bcd, input logic clr, input logic rd,
                     input logic [7:0] e, input string t);
    @(negedge clk);
    bank_sel = b; addr = a; wr_en = w; wr_data = d;
    date_bcd = bcd; clear_all = clr; rd_issue = rd;
    if (rd) begin
      exp_q.push_back(e);
      tag_q.push_back(t);
    end
  endtask

  task automatic wr(input logic b, input logic [6:0] a, input logic [7:0] d, input logic bcd);
    cyc(b, a, 1'b1, d, bcd, 1'b0, 1'b0, 8'h00, "");
  endtask

  task automatic rd(input logic b, input logic [6:0] a, input logic [7:0] e, input string t);
    cyc(b, a, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, e, t);
  endtask

  // Monitor: pops one expected byte per issued read, after the edge that loads it.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_issue) begin
        #2;
        if (exp_q.size() == 0) begin
          check(rd_data, 8'hxx, "scoreboard underflow");
        end else begin
          check(rd_data, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    for (int n = 0; n < 20000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] crc;
    crc = ref_crc(TB_ID);
    rst_n = 1'b0; bank_sel = 1'b0; addr = '0; wr_en = 1'b0;
    wr_data = '0; date_bcd = 1'b1; clear_all = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_data, 8'h00, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data, 8'h00, "R1 internal reset still held");
    repeat (3) @(negedge clk);

    // Initial erase.
    cyc(1'b0, 7'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, "");
    rd(1'b0, 7'h05, 8'h00, "R8 shared erased");
    rd(1'b1, 7'h48, 8'h00, "R8 century erased");

    // Shared lower half.
    wr(1'b0, 7'h05, 8'hA5, 1'b1);
    rd(1'b1, 7'h05, 8'hA5, "R2 bank0 write bank1 read");
    wr(1'b1, 7'h3F, 8'h3C, 1'b1);
    rd(1'b0, 7'h3F, 8'h3C, "R2 bank1 write bank0 read");

    // Bank 0 upper bytes, and bank 1 writes over the same addresses.
    wr(1'b0, 7'h40, 8'h11, 1'b1);
    wr(1'b0, 7'h60, 8'h42, 1'b1);
    wr(1'b0, 7'h7F, 8'h77, 1'b1);
    wr(1'b1, 7'h40, 8'hEE, 1'b1);
    wr(1'b1, 7'h60, 8'h99, 1'b1);
    wr(1'b1, 7'h7F, 8'hAB, 1'b1);
    rd(1'b1, 7'h40, TB_ID[7:0], "R5 id write ignored");
    rd(1'b0, 7'h40, 8'h11, "R3 bank0 0x40 kept");
    rd(1'b1, 7'h60, 8'h00, "R7 reserved reads zero");
    rd(1'b0, 7'h60, 8'h42, "R7 bank0 0x60 untouched");
    rd(1'b1, 7'h7F, 8'h00, "R7 reserved top");
    rd(1'b0, 7'h7F, 8'h77, "R3 bank0 0x7F kept");
    rd(1'b1, 7'h49, 8'h00, "R7 first reserved");

    // Identity bytes and CRC.
    for (int i = 0; i < 7; i++) begin
      rd(1'b1, 7'(8'h40 + i), TB_ID[8*i +: 8], "R4 id byte");
    end
    rd(1'b1, 7'h47, crc, "R4 crc byte");
    wr(1'b1, 7'h47, ~crc, 1'b1);
    rd(1'b1, 7'h47, crc, "R5 crc write ignored");

    // Century byte.
    wr(1'b1, 7'h48, 8'h19, 1'b1);
    rd(1'b1, 7'h48, 8'h19, "R6 bcd accepted");
    wr(1'b1, 7'h48, 8'h1A, 1'b1);
    rd(1'b1, 7'h48, 8'h19, "R6 bcd low nibble rejected");
    wr(1'b1, 7'h48, 8'hA0, 1'b1);
    rd(1'b1, 7'h48, 8'h19, "R6 bcd high nibble rejected");
    wr(1'b1, 7'h48, 8'h63, 1'b0);
    rd(1'b1, 7'h48, 8'h63, "R6 binary 99 accepted");
    wr(1'b1, 7'h48, 8'h64, 1'b0);
    rd(1'b1, 7'h48, 8'h63, "R6 binary 100 rejected");
    wr(1'b0, 7'h48, 8'h5C, 1'b1);
    rd(1'b1, 7'h48, 8'h63, "R3 bank0 0x48 separate from century");
    rd(1'b0, 7'h48, 8'h5C, "R3 bank0 0x48 stored");

    // Registered read: same-cycle write is not yet visible.
    cyc(1'b0, 7'h10, 1'b1, 8'h55, 1'b1, 1'b0, 1'b1, 8'h00, "R9 read returns old byte");
    rd(1'b0, 7'h10, 8'h55, "R9 next read returns new byte");

    // Erase with a competing write.
    cyc(1'b0, 7'h20, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h00, "");
    rd(1'b0, 7'h05, 8'h00, "R8 shared erased");
    rd(1'b0, 7'h20, 8'h00, "R8 erase beats write");
    rd(1'b0, 7'h40, 8'h00, "R8 bank0 upper erased");
    rd(1'b0, 7'h7F, 8'h00, "R8 bank0 top erased");
    rd(1'b1, 7'h48, 8'h00, "R8 century erased");
    rd(1'b1, 7'h40, TB_ID[7:0], "R8 version kept");
    rd(1'b1, 7'h47, crc, "R8 crc kept");

    cyc(1'b0, 7'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, "");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check(8'(exp_q.size()), 8'h00, "scoreboard leftover");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule